// File: doc/BRIEF.md
# Host Bridge Address Window Decoder

This block decides, for every CPU address, whether the address belongs to one of the bridge's outbound windows and what address it becomes on the far side. Each window is set by two decode registers. The low register gives the base, and the high register gives the last 2 MiB unit the window covers. A third register places the bridge's own 4 KiB internal-register space. Software programs all of them over a 32-bit write-only register bus, indexed by word offset. From these values the block derives each window's base and length, rounded to 2 MiB. It then trims every region so that none of it lands inside two fixed reserved address ranges.

The CPU address is decoded without a clock. Each window raises a hit flag when the address lies inside its trimmed span. In the same way each window drives a remapped outbound address: a remap field replaces the upper bits and the low 21 bits pass through. Writing a window's low register also loads its remap field. A low/high pair that describes a negative span is kept in the registers, but it does not disturb the mapping already in use.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset, window 0 decodes base 0x10000000 with length 0x02000000 (low 0x80, high 0x0F), window 1 decodes base 0x12000000 with length 0x02000000 (low 0x90, high 0x1F), the internal space sits at 0x14000000 with length 0x1000 (value 0xA0), and the remap fields equal the low values.
- R2: A write to the low register of window k (word offset 2k) keeps data bits 14:0 as the low value and loads the remap field of window k with data bits 10:0.
- R3: A write to the high register of window k (word offset 2k+1) keeps only data bits 6:0.
- R4: A window's mapping is recomputed only while (low & 0x7F) <= high. Otherwise the previous base and length stay in force.
- R5: Untrimmed base = low << 21 (36-bit result). Untrimmed length = ((high + 1) - (low & 0x7F)) << 21.
- R6: A write to word offset 2·NWIN keeps data bits 14:0 as the internal-space value. That region's base is value << 21 and its length is 0x1000, before trimming.
- R7: The reserved ranges are A = [0x1E000000, 0x1F100000) and B = [0x1FC00000, 0x1FD00000), exclusive upper bounds. An end (base + length) that lies inside a range is pulled down to that range's start.
- R8: A begin that lies inside a range is pushed up to that range's exclusive upper bound. Range A is handled before range B, end before begin. If end <= begin after trimming, the length is 0.
- R9: If a region's begin is below a range's start and its end is at or above that range's upper bound, the end is pulled to the range's start (A checked before B).
- R10: win_hit[k] is high exactly when win_len[k] != 0 and win_base[k] <= cpu_addr < win_base[k] + win_len[k]. isd_hit follows the same rule for the internal space. All are combinational in cpu_addr.
- R11: remap_addr[k] = (remap_k << 21) | cpu_addr[20:0], combinational in cpu_addr.
- R12: A register write lands on the clock edge that samples it. The base and length outputs change on the following edge, not before.
- R13: Writes to word offsets above 2·NWIN change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Word offset of the write |
| reg_wdata | input | 32 | Write data |
| cpu_addr | input | ADDR_W | CPU address to decode |
| win_hit | output | NWIN | Per-window hit flag |
| win_base | output | NWIN×ADDR_W | Trimmed base per window |
| win_len | output | NWIN×ADDR_W | Trimmed length per window |
| remap_addr | output | NWIN×ADDR_W | Remapped outbound address per window |
| isd_hit | output | 1 | Internal-space hit flag |
| isd_base | output | ADDR_W | Trimmed internal-space base |
| isd_len | output | ADDR_W | Trimmed internal-space length |

## Verification
The tests program windows so that each trimming rule fires on its own, in these cases:
- Spans far from the reserved ranges show whether the raw base and length arithmetic is right.
- A span whose end enters range A separates the end rule from the begin rule.
- Spans that start inside range B, or that straddle range A or both ranges, separate the begin rule and the straddle rule, and show which range is handled first.
- Low values with the upper bits 14:7 set show that the base uses all 15 bits while the length uses only bits 6:0.
- An inverted low/high pair followed by a repair shows that invalid pairs leave the mapping held.
- Hit and remap are probed at the first and last byte of a span and one byte past it.

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder #(
  parameter int NWIN   = 2,
  parameter int ADDR_W = 36,
  parameter int REG_AW = 4,
  parameter logic [NWIN*15-1:0] LO_RST  = {15'h0090, 15'h0080},
  parameter logic [NWIN*7-1:0]  HI_RST  = {7'h1f, 7'h0f},
  parameter logic [14:0]        ISD_RST = 15'h00a0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_waddr,
  input  logic [31:0]                      reg_wdata,
  input  logic [ADDR_W-1:0]                cpu_addr,
  output logic [NWIN-1:0]                  win_hit,
  output logic [NWIN-1:0][ADDR_W-1:0]      win_base,
  output logic [NWIN-1:0][ADDR_W-1:0]      win_len,
  output logic [NWIN-1:0][ADDR_W-1:0]      remap_addr,
  output logic                             isd_hit,
  output logic [ADDR_W-1:0]                isd_base,
  output logic [ADDR_W-1:0]                isd_len
);

  localparam int SHIFT = 21;
  localparam int EW    = ADDR_W + 1;
  localparam logic [EW-1:0] RA_LO = EW'(32'h1e00_0000);
  localparam logic [EW-1:0] RA_HI = EW'(32'h1f10_0000);
  localparam logic [EW-1:0] RB_LO = EW'(32'h1fc0_0000);
  localparam logic [EW-1:0] RB_HI = EW'(32'h1fd0_0000);
  localparam logic [EW-1:0] ISD_SIZE = EW'(32'h0000_1000);
  localparam logic [REG_AW-1:0] ISD_OFF = REG_AW'(2 * NWIN);

  function automatic logic [2*EW-1:0] trim(input logic [EW-1:0] b_in, input logic [EW-1:0] l_in);
    logic [EW-1:0] b, e;
    b = b_in;
    e = b_in + l_in;
    if (e >= RA_LO && e < RA_HI) e = RA_LO;
    if (b >= RA_LO && b < RA_HI) b = RA_HI;
    if (e >= RB_LO && e < RB_HI) e = RB_LO;
    if (b >= RB_LO && b < RB_HI) b = RB_HI;
    if (e >= RA_HI && b < RA_LO) e = RA_LO;
    if (e >= RB_HI && b < RB_LO) e = RB_LO;
    return {b, (e > b) ? (e - b) : '0};
  endfunction

  function automatic logic in_span(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base,
                                   input logic [ADDR_W-1:0] len);
    return (len != '0) && (a >= base) && (EW'(a) < EW'(base) + EW'(len));
  endfunction

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [14:0] LO0 = LO_RST[k*15 +: 15];
    localparam logic [6:0]  HI0 = HI_RST[k*7 +: 7];

    logic [14:0]       lo_q;
    logic [6:0]        hi_q;
    logic [10:0]       rm_q;
    logic [ADDR_W-1:0] base_q, len_q;
    logic [2*EW-1:0]   cur_t, rst_t;
    logic              ok;

    assign ok    = lo_q[6:0] <= hi_q;
    assign cur_t = trim(EW'(lo_q) << SHIFT,
                        EW'(8'({1'b0, hi_q} + 8'd1 - {1'b0, lo_q[6:0]})) << SHIFT);
    assign rst_t = trim(EW'(LO0) << SHIFT,
                        EW'(8'({1'b0, HI0} + 8'd1 - {1'b0, LO0[6:0]})) << SHIFT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q   <= LO0;
        hi_q   <= HI0;
        rm_q   <= LO0[10:0];
        base_q <= rst_t[EW +: ADDR_W];
        len_q  <= rst_t[0 +: ADDR_W];
      end else begin
        if (reg_wr && reg_waddr == REG_AW'(2 * k)) begin
          lo_q <= reg_wdata[14:0];
          rm_q <= reg_wdata[10:0];
        end
        if (reg_wr && reg_waddr == REG_AW'(2 * k + 1))
          hi_q <= reg_wdata[6:0];
        if (ok) begin
          base_q <= cur_t[EW +: ADDR_W];
          len_q  <= cur_t[0 +: ADDR_W];
        end
      end
    end

    assign win_base[k]   = base_q;
    assign win_len[k]    = len_q;
    assign win_hit[k]    = in_span(cpu_addr, base_q, len_q);
    assign remap_addr[k] = (ADDR_W'(rm_q) << SHIFT) | ADDR_W'(cpu_addr[SHIFT-1:0]);
  end

  logic [14:0]       isd_q;
  logic [ADDR_W-1:0] isd_base_q, isd_len_q;
  logic [2*EW-1:0]   isd_t, isd_rst_t;

  assign isd_t     = trim(EW'(isd_q) << SHIFT, ISD_SIZE);
  assign isd_rst_t = trim(EW'(ISD_RST) << SHIFT, ISD_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isd_q      <= ISD_RST;
      isd_base_q <= isd_rst_t[EW +: ADDR_W];
      isd_len_q  <= isd_rst_t[0 +: ADDR_W];
    end else begin
      if (reg_wr && reg_waddr == ISD_OFF)
        isd_q <= reg_wdata[14:0];
      isd_base_q <= isd_t[EW +: ADDR_W];
      isd_len_q  <= isd_t[0 +: ADDR_W];
    end
  end

  assign isd_base = isd_base_q;
  assign isd_len  = isd_len_q;
  assign isd_hit  = in_span(cpu_addr, isd_base_q, isd_len_q);

endmodule

// File: rtl/bridge_window_decoder_chk.sv
module bridge_window_decoder_chk #(
  parameter int NWIN   = 2,
  parameter int ADDR_W = 36,
  parameter int REG_AW = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [REG_AW-1:0]           reg_waddr,
  input logic [31:0]                 reg_wdata,
  input logic [ADDR_W-1:0]           cpu_addr,
  input logic [NWIN-1:0]             win_hit,
  input logic [NWIN-1:0][ADDR_W-1:0] win_base,
  input logic [NWIN-1:0][ADDR_W-1:0] win_len,
  input logic [NWIN-1:0][ADDR_W-1:0] remap_addr,
  input logic                        isd_hit,
  input logic [ADDR_W-1:0]           isd_base,
  input logic [ADDR_W-1:0]           isd_len
);
  localparam int EW = ADDR_W + 1;
  localparam logic [EW-1:0] RA_LO = EW'(32'h1e00_0000);
  localparam logic [EW-1:0] RA_HI = EW'(32'h1f10_0000);
  localparam logic [EW-1:0] RB_LO = EW'(32'h1fc0_0000);
  localparam logic [EW-1:0] RB_HI = EW'(32'h1fd0_0000);
  localparam logic [ADDR_W-1:0] MAX_LEN = ADDR_W'(32'h1000_0000);

  for (genvar k = 0; k < NWIN; k++) begin : g_chk
    // R7
    win_clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len[k] != '0) |-> !((EW'(win_base[k]) < RA_HI) && (EW'(win_base[k]) + EW'(win_len[k]) > RA_LO)));
    // R8
    win_clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len[k] != '0) |-> !((EW'(win_base[k]) < RB_HI) && (EW'(win_base[k]) + EW'(win_len[k]) > RB_LO)));
    // R2
    remap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_waddr == REG_AW'(2 * k)) |=> (remap_addr[k][31:21] == $past(reg_wdata[10:0])));
    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_len[k] <= MAX_LEN);
    // R10
    hit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit[k] |-> ((cpu_addr >= win_base[k]) && (win_len[k] != '0)));
  end

  // R6
  isd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isd_len <= ADDR_W'(32'h1000));
  // R10
  isd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isd_hit |-> (cpu_addr >= isd_base));
endmodule

bind bridge_window_decoder bridge_window_decoder_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .cpu_addr(cpu_addr), .win_hit(win_hit), .win_base(win_base), .win_len(win_len),
  .remap_addr(remap_addr), .isd_hit(isd_hit), .isd_base(isd_base), .isd_len(isd_len));

// File: tb/tb_bridge_window_decoder.sv
`timescale 1ns/1ps
module tb_bridge_window_decoder;
  localparam int NWIN = 2, AW = 36, RW = 4, EW = AW + 1;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [RW-1:0] reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic [NWIN-1:0] win_hit;
  logic [NWIN-1:0][AW-1:0] win_base, win_len, remap_addr;
  logic isd_hit;
  logic [AW-1:0] isd_base, isd_len;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_window_decoder dut (.*);

  task automatic chk(input string req, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [2*EW-1:0] model(input logic [EW-1:0] b0, input logic [EW-1:0] l0);
    logic [EW-1:0] b, e;
    b = b0; e = b0 + l0;
    if (e >= 37'h1e00_0000 && e < 37'h1f10_0000) e = 37'h1e00_0000;
    if (b >= 37'h1e00_0000 && b < 37'h1f10_0000) b = 37'h1f10_0000;
    if (e >= 37'h1fc0_0000 && e < 37'h1fd0_0000) e = 37'h1fc0_0000;
    if (b >= 37'h1fc0_0000 && b < 37'h1fd0_0000) b = 37'h1fd0_0000;
    if (e >= 37'h1f10_0000 && b < 37'h1e00_0000) e = 37'h1e00_0000;
    if (e >= 37'h1fd0_0000 && b < 37'h1fc0_0000) e = 37'h1fc0_0000;
    return {b, (e > b) ? e - b : '0};
  endfunction

  function automatic logic [2*EW-1:0] win_model(input logic [14:0] lo, input logic [6:0] hi);
    return model(EW'(lo) << 21, EW'(8'({1'b0, hi} + 8'd1 - {1'b0, lo[6:0]})) << 21);
  endfunction

  task automatic wr(input logic [RW-1:0] off, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_waddr = off; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_win(input string req, input int k, input logic [14:0] lo, input logic [6:0] hi);
    logic [2*EW-1:0] m;
    m = win_model(lo, hi);
    chk(req, $sformatf("win%0d base", k), win_base[k], m[EW +: AW]);
    chk(req, $sformatf("win%0d len", k), win_len[k], m[0 +: AW]);
  endtask

  task automatic probe(input string req, input int k, input logic [AW-1:0] a, input logic exp);
    cpu_addr = a; #1;
    chk(req, $sformatf("win%0d hit @%0h", k, a), AW'(win_hit[k]), AW'(exp));
  endtask

  task automatic t_reset;
    chk("R1", "win0 base", win_base[0], 36'h1000_0000);
    chk("R1", "win0 len", win_len[0], 36'h0200_0000);
    chk("R1", "win1 base", win_base[1], 36'h1200_0000);
    chk("R1", "win1 len", win_len[1], 36'h0200_0000);
    chk("R1", "isd base", isd_base, 36'h1400_0000);
    chk("R1", "isd len", isd_len, 36'h1000);
    cpu_addr = 36'h123; #1;
    chk("R1", "win0 remap", remap_addr[0], 36'h1000_0123);
    chk("R1", "win1 remap", remap_addr[1], 36'h1200_0123);
    probe("R10", 0, 36'h1000_0000, 1'b1);
    probe("R10", 0, 36'h11ff_ffff, 1'b1);
    probe("R10", 0, 36'h1200_0000, 1'b0);
    probe("R10", 1, 36'h1200_0000, 1'b1);
    cpu_addr = 36'h1400_0fff; #1; chk("R10", "isd hit last", AW'(isd_hit), 1);
    cpu_addr = 36'h1400_1000; #1; chk("R10", "isd hit past", AW'(isd_hit), 0);
  endtask

  task automatic t_low_write;
    logic [2*EW-1:0] m;
    m = win_model(15'h0c85, 7'h0f);
    @(negedge clk); reg_wr = 1'b1; reg_waddr = 4'd0; reg_wdata = 32'hffff_8c85;
    @(negedge clk); reg_wr = 1'b0;
    chk("R12", "win0 base held one cycle", win_base[0], 36'h1000_0000);
    @(negedge clk);
    chk("R12", "win0 base after", win_base[0], m[EW +: AW]);
    chk("R2", "win0 base full 15 bits", win_base[0], 36'h1_90a0_0000);
    chk("R5", "win0 len masked low", win_len[0], 36'h0160_0000);
    cpu_addr = 36'h0_0abc_def1; #1;
    chk("R11", "remap bits 10:0", remap_addr[0], 36'h90a0_0000 | 36'h1c_def1);
  endtask

  task automatic t_high_write;
    wr(4'd0, 32'h0000_0080);
    wr(4'd1, 32'hffff_ff3f);
    chk_win("R3", 0, 15'h0080, 7'h3f);
    chk("R3", "win0 len", win_len[0], 36'h0800_0000);
    probe("R10", 0, 36'h17ff_ffff, 1'b1);
    probe("R10", 0, 36'h1800_0000, 1'b0);
    probe("R10", 0, 36'h0fff_ffff, 1'b0);
  endtask

  task automatic t_invalid;
    wr(4'd2, 32'h0000_0085);
    wr(4'd3, 32'h0000_000f);
    chk_win("R4", 1, 15'h0085, 7'h0f);
    wr(4'd3, 32'h0000_0003);
    chk("R4", "win1 base held", win_base[1], 36'h10a0_0000);
    chk("R4", "win1 len held", win_len[1], 36'h0160_0000);
    cpu_addr = 36'h4; #1;
    chk("R4", "remap still loaded", remap_addr[1], 36'h10a0_0004);
    wr(4'd2, 32'h0000_0081);
    chk("R4", "win1 len repaired", win_len[1], 36'h0060_0000);
    chk("R4", "win1 base repaired", win_base[1], 36'h1020_0000);
  endtask

  task automatic t_clip;
    wr(4'd0, 32'h0000_00e0);
    wr(4'd1, 32'h0000_0070);
    chk("R7", "end pulled len", win_len[0], 36'h0200_0000);
    chk("R7", "end pulled base", win_base[0], 36'h1c00_0000);
    probe("R7", 0, 36'h1dff_ffff, 1'b1);
    probe("R7", 0, 36'h1e00_0000, 1'b0);
    wr(4'd2, 32'h0000_00fe);
    wr(4'd3, 32'h0000_007f);
    chk("R8", "begin pushed base", win_base[1], 36'h1fd0_0000);
    chk("R8", "begin pushed len", win_len[1], 36'h0030_0000);
    probe("R8", 1, 36'h1fcf_ffff, 1'b0);
    probe("R8", 1, 36'h1fd0_0000, 1'b1);
    wr(4'd1, 32'h0000_007b);
    chk("R9", "straddle A len", win_len[0], 36'h0200_0000);
    chk_win("R9", 0, 15'h00e0, 7'h7b);
    wr(4'd0, 32'h0000_00f0);
    wr(4'd1, 32'h0000_007f);
    chk("R9", "begin A then straddle B base", win_base[0], 36'h1f10_0000);
    chk("R9", "begin A then straddle B len", win_len[0], 36'h00b0_0000);
  endtask

  task automatic t_isd;
    wr(4'd4, 32'hffff_80a5);
    chk("R6", "isd base", isd_base, 36'h14a0_0000);
    chk("R6", "isd len", isd_len, 36'h1000);
    wr(4'd4, 32'h0000_00f4);
    chk("R8", "isd in reserved len", isd_len, 36'h0);
    cpu_addr = 36'h1e80_0000; #1; chk("R10", "isd zero-len hit", AW'(isd_hit), 0);
    wr(4'd4, 32'h0000_00a0);
  endtask

  task automatic t_ignored;
    logic [NWIN-1:0][AW-1:0] b0, l0;
    logic [AW-1:0] ib;
    b0 = win_base; l0 = win_len; ib = isd_base;
    wr(4'd5, 32'hffff_ffff);
    wr(4'd15, 32'h0000_0000);
    cpu_addr = 36'h55; #1;
    chk("R13", "win0 base", win_base[0], b0[0]);
    chk("R13", "win1 len", win_len[1], l0[1]);
    chk("R13", "isd base", isd_base, ib);
    chk("R13", "win0 remap", remap_addr[0], 36'h1e00_0055);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_low_write;
    t_high_write;
    t_invalid;
    t_clip;
    t_isd;
    t_ignored;
    done = 1;
    report;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
    end
  end
endmodule